// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block gathers a wide bank of interrupt lines, by default 1024, and folds them onto four vectored outputs, vector 0 to vector 3. Every input carries its own enable bit and a route field that picks one of the four outputs. A rising edge on an input, or a software write, marks that input pending. Each output takes one pending, enabled, routed input at a time. It latches that input's number into a readable vector register and raises a one-cycle pulse. It then stays on that number until a clear command names it.

After the clear, the output moves to the next pending input routed to it, if there is one, and pulses again. The four pulses also drive a slice of a wider core-side interrupt vector (8 lines by default), so they land on fixed core interrupt lines. Software reaches the block through a plain word-addressed read/write port. The port holds the per-input configuration, a software-assert window, the vector registers and a per-output status word.

Top module: `irq_vector_funnel`

## Requirements
- R1: A 0-to-1 transition on `irq_in[i]` sets the pending flag of input i on that clock edge. A line held high sets it only once.
- R2: A write to address {2'b00, i} loads the enable of input i from `reg_wdata[0]` and its route from `reg_wdata[2:1]`. A read of that address returns {pending, route, enable} in bits 3..0.
- R3: An input whose enable is 0 is never reported, even though its pending flag stays set.
- R4: When several enabled pending inputs share a route, the output reports the lowest-numbered one.
- R5: An idle output with a candidate latches the candidate's number on the next edge and raises `vec_pulse[k]` for exactly one cycle.
- R6: While an output holds a number, it neither pulses nor changes that number, whatever other inputs become pending.
- R7: `clr_valid` with `clr_id` equal to an output's held number retires that input, which clears its pending flag and frees the output. A remaining candidate is pulsed one edge later.
- R8: A clear whose `clr_id` matches no held number changes nothing.
- R9: A write to region 2'b10 sets the pending flag of input `reg_wdata`, with the same effect as a hardware edge.
- R10: A read of address {2'b01, k} returns output k's held number, or all ones (11 bits) when output k holds nothing.
- R11: A read of address {2'b11, k} returns bit 0 = holding a number, and bit 1 = some other candidate waiting on output k.
- R12: `core_irq[CORE_BASE+k]` equals `vec_pulse[k]`. All other core lines stay 0.
- R13: After reset, no input is pending or enabled, no output pulses, and every vector register reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Word address: region in the top two bits, index below |
| reg_wdata | input | IDX_W | Write data |
| reg_rdata | output | IDX_W+1 | Read data (combinational) |
| clr_valid | input | 1 | Clear command strobe |
| clr_id | input | IDX_W | Input number to retire |
| vec_pulse | output | 4 | One-cycle report pulse per output |
| core_irq | output | CORE_LINES | Core-side interrupt lines carrying the pulses |

## Verification
The bench targets these corner cases and the failure each one would expose:
- **Several inputs pending on one output at once.** A scan picking the highest or the first-seen input reports the wrong number.
- **New inputs arriving while an output holds a number.** A design without the hold re-pulses or overwrites the vector.
- **Clears naming an input that is not held.** A loose compare retires the wrong input.
- **Disabled inputs that are pending.** These must stay silent while their pending flag is still visible in the configuration readback.
- **Randomised drains.** Random routes and enables, followed by draining each output, check the full order of reported numbers and the two-edge gap between a clear and the next pulse.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  localparam int unsigned NUM_VEC = 4;
  localparam int unsigned ROUTE_W = 2;
  localparam logic [1:0] RGN_CFG  = 2'd0;
  localparam logic [1:0] RGN_VEC  = 2'd1;
  localparam logic [1:0] RGN_SET  = 2'd2;
  localparam logic [1:0] RGN_STAT = 2'd3;
endpackage

// File: rtl/ivf_rst_sync.sv
module ivf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ivf_pick.sv
module ivf_pick #(
  parameter int unsigned N = 1024,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivf_slot.sv
module ivf_slot #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_found,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_id,
  output logic             busy,
  output logic [IDX_W-1:0] held_idx,
  output logic             pulse,
  output logic             retire
);
  logic             busy_d, pulse_d;
  logic [IDX_W-1:0] held_d;
  logic             held_en;

  assign retire = busy && clr_valid && (clr_id == held_idx);

  always_comb begin
    busy_d  = busy;
    pulse_d = 1'b0;
    held_en = 1'b0;
    held_d  = cand_idx;
    if (retire) begin
      busy_d = 1'b0;
    end else if (!busy && cand_found) begin
      busy_d  = 1'b1;
      pulse_d = 1'b1;
      held_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      busy  <= busy_d;
      pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_idx <= '0;
    else if (held_en) held_idx <= held_d;
  end

  // R5: a report pulse lasts one cycle and comes with a held number
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r5_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> busy);
  // R6: without a matching clear the number stays put and no pulse fires
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(clr_valid && clr_id == held_idx)) |=> (busy && !pulse && $stable(held_idx)));
  // R7: a matching clear frees the output on the next edge
  a_r7_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clr_valid && clr_id == held_idx) |=> (!busy && !pulse));
endmodule

// File: rtl/irq_vector_funnel.sv
module irq_vector_funnel
  import ivf_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 1024,
  parameter int unsigned CORE_LINES = 8,
  parameter int unsigned CORE_BASE  = 2,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
  localparam int unsigned ADDR_W = IDX_W + 2,
  localparam int unsigned RD_W   = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IRQ-1:0]    irq_in,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [IDX_W-1:0]      reg_wdata,
  output logic [RD_W-1:0]       reg_rdata,
  input  logic                  clr_valid,
  input  logic [IDX_W-1:0]      clr_id,
  output logic [NUM_VEC-1:0]    vec_pulse,
  output logic [CORE_LINES-1:0] core_irq
);
  logic rst_s;

  logic [NUM_IRQ-1:0]   irq_q, pend_q, pend_d, en_q;
  logic [ROUTE_W-1:0]   route_q [NUM_IRQ];
  logic [1:0]           rgn;
  logic [IDX_W-1:0]     offs;
  logic                 cfg_we, set_we;

  logic [NUM_IRQ-1:0]   cand   [NUM_VEC];
  logic [NUM_VEC-1:0]   found, busy, retire;
  logic [IDX_W-1:0]     pick   [NUM_VEC];
  logic [IDX_W-1:0]     held   [NUM_VEC];

  ivf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  assign rgn    = reg_addr[ADDR_W-1 -: 2];
  assign offs   = reg_addr[IDX_W-1:0];
  assign cfg_we = reg_wr && (rgn == RGN_CFG);
  assign set_we = reg_wr && (rgn == RGN_SET);

  // pending next state: retire first, then new events win
  always_comb begin
    pend_d = pend_q;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (retire[k]) pend_d[held[k]] = 1'b0;
    end
    pend_d = pend_d | (irq_in & ~irq_q);
    if (set_we) pend_d[reg_wdata] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) route_q[i] <= '0;
    end else if (cfg_we) begin
      en_q[offs]    <= reg_wdata[0];
      route_q[offs] <= reg_wdata[2:1];
    end
  end

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        cand[k][i] = pend_q[i] && en_q[i] && (route_q[i] == ROUTE_W'(k))
                     && !(busy[k] && held[k] == IDX_W'(i));
      end
    end

    ivf_pick #(.N(NUM_IRQ)) u_pick (
      .cand (cand[k]),
      .found(found[k]),
      .idx  (pick[k])
    );

    ivf_slot #(.IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_s),
      .cand_found(found[k]),
      .cand_idx  (pick[k]),
      .clr_valid (clr_valid),
      .clr_id    (clr_id),
      .busy      (busy[k]),
      .held_idx  (held[k]),
      .pulse     (vec_pulse[k]),
      .retire    (retire[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (rgn)
      RGN_CFG:  reg_rdata = RD_W'({pend_q[offs], route_q[offs], en_q[offs]});
      RGN_VEC:  reg_rdata = busy[offs[1:0]] ? {1'b0, held[offs[1:0]]} : '1;
      RGN_STAT: reg_rdata = RD_W'({found[offs[1:0]], busy[offs[1:0]]});
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    core_irq = '0;
    core_irq[CORE_BASE +: NUM_VEC] = vec_pulse;
  end

  // R12: only the mapped core lines ever carry a pulse
  a_r12_core_lines: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(core_irq) == $countones(vec_pulse));
  // R3: a pulse only follows a cycle where that output had an enabled candidate
  a_r3_pulse_cause: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy[0] && !found[0]) |=> !vec_pulse[0]);
endmodule

// File: tb/irq_vector_funnel_tb_top.sv
module irq_vector_funnel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI   = 1024;
  localparam int IW   = 10;
  localparam int BASE = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NI-1:0]   irq_in;
  logic            reg_wr;
  logic [IW+1:0]   reg_addr;
  logic [IW-1:0]   reg_wdata;
  logic [IW:0]     reg_rdata;
  logic            clr_valid;
  logic [IW-1:0]   clr_id;
  logic [3:0]      vec_pulse;
  logic [7:0]      core_irq;

  int total = 0;
  int bad   = 0;

  logic [NI-1:0] pend_m, en_m;
  logic [1:0]    route_m [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_funnel dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_valid(clr_valid), .clr_id(clr_id), .vec_pulse(vec_pulse),
    .core_irq(core_irq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] rg, input int off, output logic [31:0] d);
    reg_addr = {rg, IW'(off)};
    #1;
    d = 32'(reg_rdata);
  endtask

  task automatic wr_cfg(input int idx, input logic en, input logic [1:0] rt);
    reg_addr  = {2'b00, IW'(idx)};
    reg_wdata = IW'({rt, en});
    reg_wr    = 1'b1;
    cyc();
    reg_wr    = 1'b0;
    en_m[idx] = en;
    route_m[idx] = rt;
  endtask

  task automatic clear(input int idx);
    clr_id    = IW'(idx);
    clr_valid = 1'b1;
    cyc();
    clr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    clr_valid = 1'b0; clr_id = '0;
    pend_m = '0; en_m = '0;
    for (int i = 0; i < NI; i++) route_m[i] = 2'd0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
  endtask

  // expected report of output k: lowest enabled pending input routed there
  task automatic exp_pick(input int k, output logic f, output int idx);
    f = 1'b0; idx = 0;
    for (int i = NI - 1; i >= 0; i--)
      if (pend_m[i] && en_m[i] && route_m[i] == 2'(k)) begin f = 1'b1; idx = i; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        f;
    int          e;
    int          list [40];
    void'($urandom(32'd4711));
    do_reset();

    // R13 reset state
    check("R13 pulses", 32'(vec_pulse), 0);
    for (int k = 0; k < 4; k++) begin
      rd(2'b01, k, d); check("R13 vector idle", d, 32'h7FF);
    end
    rd(2'b00, 5, d); check("R13 cfg", d, 0);

    // R2 config readback
    wr_cfg(5, 1'b1, 2'd2);
    rd(2'b00, 5, d); check("R2 cfg readback", d, 5);

    // R3 disabled input pending but silent
    wr_cfg(7, 1'b0, 2'd0);
    irq_in[7] = 1'b1; cyc(); cyc();
    check("R3 no pulse", 32'(vec_pulse[0]), 0);
    rd(2'b01, 0, d); check("R3 vector idle", d, 32'h7FF);
    rd(2'b00, 7, d); check("R1 R3 pending visible", d, 8);
    rd(2'b11, 0, d); check("R3 status", d, 0);

    // R5 R12 report of input 5 on output 2
    irq_in[5] = 1'b1; cyc();
    check("R5 no pulse before latch", 32'(vec_pulse), 0);
    cyc();
    check("R5 pulse", 32'(vec_pulse), 32'h4);
    check("R12 core line", 32'(core_irq), 32'(1 << (BASE + 2)));
    rd(2'b01, 2, d); check("R10 vector", d, 5);
    cyc();
    check("R5 single pulse", 32'(vec_pulse), 0);

    // R1 held line does not re-pend after retire
    // R6 hold while busy
    wr_cfg(3, 1'b1, 2'd2);
    irq_in[3] = 1'b1; cyc(); cyc();
    check("R6 no second pulse", 32'(vec_pulse), 0);
    rd(2'b01, 2, d); check("R6 vector held", d, 5);
    rd(2'b11, 2, d); check("R11 busy and waiting", d, 3);

    // R8 clear of a number not held
    clear(3);
    rd(2'b01, 2, d); check("R8 vector unchanged", d, 5);
    cyc();
    check("R8 no pulse", 32'(vec_pulse), 0);
    rd(2'b00, 3, d); check("R8 pending kept", d, 32'hD);

    // R7 clear of the held number
    clear(5);
    check("R7 no pulse at free", 32'(vec_pulse), 0);
    rd(2'b01, 2, d); check("R7 vector idle after clear", d, 32'h7FF);
    cyc();
    check("R7 next pulse", 32'(vec_pulse), 32'h4);
    rd(2'b01, 2, d); check("R7 next vector", d, 3);
    rd(2'b00, 5, d); check("R7 R1 retired not re-pended", d, 5);
    clear(3); cyc();
    rd(2'b11, 2, d); check("R11 idle status", d, 0);

    // R9 software assert
    wr_cfg(9, 1'b1, 2'd1);
    reg_addr = {2'b10, IW'(0)}; reg_wdata = IW'(9); reg_wr = 1'b1;
    cyc(); reg_wr = 1'b0;
    check("R9 no pulse yet", 32'(vec_pulse), 0);
    cyc();
    check("R9 pulse", 32'(vec_pulse), 32'h2);
    check("R12 core line 1", 32'(core_irq), 32'(1 << (BASE + 1)));
    rd(2'b01, 1, d); check("R9 vector", d, 9);
    clear(9); cyc();

    // R4 simultaneous arrivals
    wr_cfg(20, 1'b1, 2'd0);
    wr_cfg(12, 1'b1, 2'd0);
    irq_in[20] = 1'b1; irq_in[12] = 1'b1; cyc(); cyc();
    rd(2'b01, 0, d); check("R4 lowest chosen", d, 12);

    // randomised rounds
    for (int r = 0; r < 6; r++) begin
      logic [NI-1:0] rv;
      do_reset();
      for (int j = 0; j < 40; j++) begin
        list[j] = int'($urandom % NI);
        wr_cfg(list[j], ($urandom % 4) != 0, 2'($urandom % 4));
      end
      rv = '0;
      for (int j = 0; j < 30; j++) rv[list[$urandom % 40]] = 1'b1;
      for (int j = 0; j < 20; j++) rv[$urandom % NI] = 1'b1;
      irq_in = rv; pend_m = rv;
      cyc(); cyc();
      for (int k = 0; k < 4; k++) begin
        exp_pick(k, f, e);
        check("R5 R4 random pulse", 32'(vec_pulse[k]), 32'(f));
      end
      irq_in = '0;
      for (int k = 0; k < 4; k++) begin
        exp_pick(k, f, e);
        while (f) begin
          rd(2'b01, k, d); check("R4 R7 random order", d, e);
          clear(e); pend_m[e] = 1'b0;
          cyc();
          exp_pick(k, f, e);
          check("R7 random next pulse", 32'(vec_pulse[k]), 32'(f));
        end
        rd(2'b01, k, d); check("R3 R10 drained idle", d, 32'h7FF);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule